// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home side of a directory protocol for a small shared-memory system with a handful of caching nodes. For every memory block it keeps one directory entry: a coherence state (uncached, shared or exclusive) and a node bit-vector. The bit-vector holds the set of sharers in the shared state and a single one-hot owner in the exclusive state. Requests from the nodes arrive on per-node request lanes that feed one arbitrated request port. The controller answers on a single message port with data replies, point-to-point invalidates and fetch-from-owner commands. Every change to the backing memory also appears on a registered memory-write port.

The controller is the ordering point for each block. It accepts one request at a time and finishes it before it grants the next. When several nodes ask in the same cycle, the lowest node index goes first and the others keep their requests raised. When a block is held exclusive by another node, the controller sends that owner a fetch. It refuses all new requests until the owner's data comes back on the owner-response input. It then writes that data to memory and forwards it to the requester.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is uncached with no sharers, every memory word reads as zero, and no message, grant or memory write is issued until a request is accepted.
- R2: A read miss (request kind 0) to an uncached or shared block returns a data reply (message type 0) to the requester carrying the memory word, and leaves the block shared with the requester added to the sharers.
- R3: A write miss (request kind 1) to an uncached block returns a data reply with the memory word, and makes the requester the exclusive owner.
- R4: A write miss to a shared block first sends one invalidate (message type 1) per cycle to every sharer other than the requester, in ascending node order, then sends the data reply, and makes the requester the exclusive owner.
- R5: A read miss to a block owned exclusively by another node sends a fetch (message type 2) to the owner. When the owner's data arrives, it is written to memory (visible on the memory-write port) and returned in the data reply. The block becomes shared by the old owner and the requester.
- R6: A write miss to a block owned exclusively by another node fetches and writes back the owner's data as in R5, replies with it, and makes the requester the new exclusive owner.
- R7: A write-back (request kind 2) from the exclusive owner writes its data to memory through the memory-write port, sends no message, and returns the block to uncached.
- R8: A write-back from a node that is not the exclusive owner, or a request of kind 3, is accepted and ignored: no message, no memory write and no directory change.
- R9: A read or write miss from the node that already owns the block exclusively is answered from memory with no fetch. A read leaves the block shared by that node alone; a write keeps it exclusive.
- R10: At most one request is granted at a time, only while the controller is idle. Among same-cycle requests the lowest node index wins, and a losing request stays pending until granted.
- R11: While an owner fetch is outstanding no request is granted, and an owner response that arrives when no fetch is outstanding has no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NODES | Per-node request pending |
| req_kind | input | 2*NODES | Per-node request kind: 0 read miss, 1 write miss, 2 write-back |
| req_addr | input | BLK_W*NODES | Per-node block index |
| req_wdata | input | DATA_W*NODES | Per-node write-back data |
| req_grant | output | NODES | One-hot acceptance of a request in this cycle |
| own_valid | input | 1 | Owner data response strobe |
| own_data | input | DATA_W | Data returned by the fetched owner |
| msg_valid | output | 1 | Outgoing message strobe |
| msg_type | output | 2 | 0 data reply, 1 invalidate, 2 fetch |
| msg_dest | output | NODE_W | Destination node |
| msg_addr | output | BLK_W | Block index the message refers to |
| msg_data | output | DATA_W | Reply data (zero for invalidate and fetch) |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | BLK_W | Memory write block index |
| mem_wr_data | output | DATA_W | Memory write data |

## Verification
A corrupted sharer vector shows up at the ports as an invalidate that is missing or sent to the wrong node on the next write miss to that block. A wrong state shows up as a fetch where a plain reply was due, or the reverse, in the same transaction, which is at most a few cycles after the grant. Stale memory shows up as wrong reply data on the next miss to the block. For this reason the bench runs a long pseudo-random mix of misses and write-backs over four nodes and four blocks and compares every message and memory write against a reference model. It also runs directed cases for same-cycle arbitration, the stall during a fetch and stray owner responses.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_LOOK,
    FS_INVAL,
    FS_WAIT,
    FS_REPLY
  } fstate_e;

  localparam logic [1:0] RK_READ  = 2'd0;
  localparam logic [1:0] RK_WRITE = 2'd1;
  localparam logic [1:0] RK_EVICT = 2'd2;

  localparam logic [1:0] MT_DATA  = 2'd0;
  localparam logic [1:0] MT_INVAL = 2'd1;
  localparam logic [1:0] MT_FETCH = 2'd2;

endpackage

// File: rtl/dir_prio_arb.sv
module dir_prio_arb #(
  parameter int NODES = 4,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [NODES-1:0]  req,
  output logic [NODES-1:0]  grant,
  output logic [NODE_W-1:0] idx,
  output logic              any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = NODE_W'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  rd_addr,
  output dstate_e           rd_st,
  output logic [NODES-1:0]  rd_vec,
  input  logic              we,
  input  logic [BLK_W-1:0]  wr_addr,
  input  dstate_e           wr_st,
  input  logic [NODES-1:0]  wr_vec
);

  dstate_e          st_q  [BLOCKS];
  logic [NODES-1:0] vec_q [BLOCKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b]  <= DS_UNC;
        vec_q[b] <= '0;
      end
    end else if (we) begin
      st_q[wr_addr]  <= wr_st;
      vec_q[wr_addr] <= wr_vec;
    end
  end

  assign rd_st  = st_q[rd_addr];
  assign rd_vec = vec_q[rd_addr];

  // R1: an uncached entry never carries presence bits
  a_r1_unc_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_st == DS_UNC) |-> (rd_vec == '0));

  // R3: an exclusive entry names exactly one owner
  a_r3_exc_single: assert property (@(posedge clk) disable iff (rst)
    (rd_st == DS_EXC) |-> $onehot(rd_vec));

  // R2: a shared entry has at least one sharer
  a_r2_shr_nonempty: assert property (@(posedge clk) disable iff (rst)
    (rd_st == DS_SHR) |-> (rd_vec != '0));

endmodule

// File: rtl/dir_data_mem.sv
module dir_data_mem #(
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk,
  input  logic [BLK_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [BLK_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem [BLOCKS];

  initial begin
    for (int b = 0; b < BLOCKS; b++) mem[b] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NODES-1:0]          req_valid,
  input  logic [2*NODES-1:0]        req_kind,
  input  logic [BLK_W*NODES-1:0]    req_addr,
  input  logic [DATA_W*NODES-1:0]   req_wdata,
  output logic [NODES-1:0]          req_grant,
  input  logic                      own_valid,
  input  logic [DATA_W-1:0]         own_data,
  output logic                      msg_valid,
  output logic [1:0]                msg_type,
  output logic [NODE_W-1:0]         msg_dest,
  output logic [BLK_W-1:0]          msg_addr,
  output logic [DATA_W-1:0]         msg_data,
  output logic                      mem_wr_en,
  output logic [BLK_W-1:0]          mem_wr_addr,
  output logic [DATA_W-1:0]         mem_wr_data
);

  fstate_e fs_q;

  // ---------------- arbitration ----------------
  logic [NODES-1:0]  arb_req;
  logic [NODE_W-1:0] arb_idx;
  logic              arb_any;

  assign arb_req = req_valid & {NODES{fs_q == FS_IDLE}};

  dir_prio_arb #(.NODES(NODES)) arb_i (
    .req   (arb_req),
    .grant (req_grant),
    .idx   (arb_idx),
    .any   (arb_any)
  );

  logic [BLK_W-1:0]  sel_addr;
  logic [1:0]        sel_kind;
  logic [DATA_W-1:0] sel_wdata;

  assign sel_addr  = req_addr[arb_idx*BLK_W +: BLK_W];
  assign sel_kind  = req_kind[arb_idx*2 +: 2];
  assign sel_wdata = req_wdata[arb_idx*DATA_W +: DATA_W];

  // ---------------- accepted request ----------------
  logic [NODE_W-1:0] cur_node;
  logic [1:0]        cur_kind;
  logic [BLK_W-1:0]  cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [NODES-1:0]  req_bit;

  assign req_bit = NODES'(1) << cur_node;

  // ---------------- directory and memory ----------------
  dstate_e          t_st;
  logic [NODES-1:0] t_vec;
  logic             tbl_we;
  dstate_e          tbl_wst;
  logic [NODES-1:0] tbl_wvec;

  dstate_e           nst_q;
  logic [NODES-1:0]  nvec_q;
  logic [NODES-1:0]  inv_q;
  logic [DATA_W-1:0] dat_q;

  dir_table #(.NODES(NODES), .BLOCKS(BLOCKS)) table_i (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (cur_addr),
    .rd_st   (t_st),
    .rd_vec  (t_vec),
    .we      (tbl_we),
    .wr_addr (cur_addr),
    .wr_st   (tbl_wst),
    .wr_vec  (tbl_wvec)
  );

  logic [DATA_W-1:0] mem_rdata;
  logic              mw_we;
  logic [DATA_W-1:0] mw_data;

  dir_data_mem #(.BLOCKS(BLOCKS), .DATA_W(DATA_W)) mem_i (
    .clk     (clk),
    .rd_addr (sel_addr),
    .rd_data (mem_rdata),
    .we      (mw_we),
    .wr_addr (cur_addr),
    .wr_data (mw_data)
  );

  // ---------------- action planning ----------------
  dstate_e          p_st;
  logic [NODES-1:0] p_vec;
  logic [NODES-1:0] p_inv;
  logic             p_fetch;
  logic             p_evict;
  logic             p_drop;

  always_comb begin
    p_st    = DS_SHR;
    p_vec   = req_bit;
    p_inv   = '0;
    p_fetch = 1'b0;
    p_evict = 1'b0;
    p_drop  = 1'b0;
    case (cur_kind)
      RK_READ: begin
        p_st = DS_SHR;
        if (t_st == DS_EXC) begin
          if (t_vec != req_bit) begin
            p_fetch = 1'b1;
            p_vec   = t_vec | req_bit;
          end
        end else if (t_st == DS_SHR) begin
          p_vec = t_vec | req_bit;
        end
      end
      RK_WRITE: begin
        p_st = DS_EXC;
        if (t_st == DS_SHR) p_inv = t_vec & ~req_bit;
        if (t_st == DS_EXC && t_vec != req_bit) p_fetch = 1'b1;
      end
      RK_EVICT: begin
        if (t_st == DS_EXC && t_vec == req_bit) p_evict = 1'b1;
        else p_drop = 1'b1;
      end
      default: p_drop = 1'b1;
    endcase
  end

  // lowest set bit of the directory vector (the owner in exclusive state)
  logic [NODE_W-1:0] own_idx;
  always_comb begin
    own_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) if (t_vec[i]) own_idx = NODE_W'(i);
  end

  // lowest pending invalidate target
  logic [NODE_W-1:0] inv_idx;
  logic              inv_last;
  always_comb begin
    inv_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) if (inv_q[i]) inv_idx = NODE_W'(i);
  end
  assign inv_last = ((inv_q & (inv_q - NODES'(1))) == '0);

  // ---------------- write strobes ----------------
  assign tbl_we   = (fs_q == FS_REPLY) || (fs_q == FS_LOOK && p_evict);
  assign tbl_wst  = (fs_q == FS_REPLY) ? nst_q : DS_UNC;
  assign tbl_wvec = (fs_q == FS_REPLY) ? nvec_q : '0;

  assign mw_we   = (fs_q == FS_LOOK && p_evict) || (fs_q == FS_WAIT && own_valid);
  assign mw_data = (fs_q == FS_LOOK) ? cur_wdata : own_data;

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q        <= FS_IDLE;
      cur_node    <= '0;
      cur_kind    <= RK_READ;
      cur_addr    <= '0;
      cur_wdata   <= '0;
      nst_q       <= DS_UNC;
      nvec_q      <= '0;
      inv_q       <= '0;
      dat_q       <= '0;
      msg_valid   <= 1'b0;
      msg_type    <= MT_DATA;
      msg_dest    <= '0;
      msg_addr    <= '0;
      msg_data    <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      msg_valid   <= 1'b0;
      mem_wr_en   <= mw_we;
      mem_wr_addr <= cur_addr;
      mem_wr_data <= mw_data;
      case (fs_q)
        FS_IDLE: begin
          if (arb_any) begin
            cur_node  <= arb_idx;
            cur_kind  <= sel_kind;
            cur_addr  <= sel_addr;
            cur_wdata <= sel_wdata;
            fs_q      <= FS_LOOK;
          end
        end
        FS_LOOK: begin
          dat_q  <= mem_rdata;
          nst_q  <= p_st;
          nvec_q <= p_vec;
          if (p_evict || p_drop) begin
            fs_q <= FS_IDLE;
          end else if (p_fetch) begin
            msg_valid <= 1'b1;
            msg_type  <= MT_FETCH;
            msg_dest  <= own_idx;
            msg_addr  <= cur_addr;
            msg_data  <= '0;
            fs_q      <= FS_WAIT;
          end else if (p_inv != '0) begin
            inv_q <= p_inv;
            fs_q  <= FS_INVAL;
          end else begin
            fs_q <= FS_REPLY;
          end
        end
        FS_INVAL: begin
          msg_valid <= 1'b1;
          msg_type  <= MT_INVAL;
          msg_dest  <= inv_idx;
          msg_addr  <= cur_addr;
          msg_data  <= '0;
          inv_q     <= inv_q & ~(NODES'(1) << inv_idx);
          if (inv_last) fs_q <= FS_REPLY;
        end
        FS_WAIT: begin
          if (own_valid) begin
            dat_q <= own_data;
            fs_q  <= FS_REPLY;
          end
        end
        FS_REPLY: begin
          msg_valid <= 1'b1;
          msg_type  <= MT_DATA;
          msg_dest  <= cur_node;
          msg_addr  <= cur_addr;
          msg_data  <= dat_q;
          fs_q      <= FS_IDLE;
        end
        default: fs_q <= FS_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R10: never more than one grant
  a_r10_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_grant));

  // R10: a grant only goes to a raised request with no lower raised request
  a_r10_grant_lowest: assert property (@(posedge clk) disable iff (rst)
    (req_grant != '0) |-> (((req_grant & ~req_valid) == '0) &&
                           ((req_valid & (req_grant - NODES'(1))) == '0)));

  // R11: nothing is granted while an owner fetch is outstanding
  a_r11_no_grant_waiting: assert property (@(posedge clk) disable iff (rst)
    (fs_q == FS_WAIT) |-> (req_grant == '0));

  // R4: an invalidate never targets the requesting node
  a_r4_inval_not_requester: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == MT_INVAL) |-> (msg_dest != cur_node));

  // R5: a fetch is always followed by the wait for the owner
  a_r5_fetch_waits: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == MT_FETCH) |-> (fs_q == FS_WAIT));

  // R8: memory is only written by an owner response or an owner write-back
  a_r8_mem_wr_source: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> ($past(fs_q == FS_WAIT && own_valid) || $past(fs_q == FS_LOOK)));

endmodule

// File: tb/dir_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;

  localparam int N  = 4;
  localparam int B  = 4;
  localparam int DW = 16;
  localparam int NWD = 2;
  localparam int AWD = 2;

  localparam int K_RD = 0, K_WR = 1, K_WB = 2, K_BAD = 3;
  localparam int M_DATA = 0, M_INV = 1, M_FETCH = 2;
  localparam int S_UNC = 0, S_SHR = 1, S_EXC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]     req_valid = '0;
  logic [2*N-1:0]   req_kind  = '0;
  logic [AWD*N-1:0] req_addr  = '0;
  logic [DW*N-1:0]  req_wdata = '0;
  logic [N-1:0]     req_grant;
  logic             own_valid = 1'b0;
  logic [DW-1:0]    own_data  = '0;
  logic             msg_valid;
  logic [1:0]       msg_type;
  logic [NWD-1:0]   msg_dest;
  logic [AWD-1:0]   msg_addr;
  logic [DW-1:0]    msg_data;
  logic             mem_wr_en;
  logic [AWD-1:0]   mem_wr_addr;
  logic [DW-1:0]    mem_wr_data;

  dir_home_ctrl #(.NODES(N), .BLOCKS(B), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_grant(req_grant),
    .own_valid(own_valid), .own_data(own_data),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_dest(msg_dest),
    .msg_addr(msg_addr), .msg_data(msg_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // message and memory-write monitors
  logic [1:0]     q_ty [64];
  logic [NWD-1:0] q_de [64];
  logic [AWD-1:0] q_ad [64];
  logic [DW-1:0]  q_da [64];
  int q_wr = 0, q_rd = 0;
  int mw_cnt = 0;
  logic [AWD-1:0] mw_addr = '0;
  logic [DW-1:0]  mw_data = '0;

  always @(negedge clk) begin
    if (!rst && msg_valid) begin
      q_ty[q_wr % 64] = msg_type;
      q_de[q_wr % 64] = msg_dest;
      q_ad[q_wr % 64] = msg_addr;
      q_da[q_wr % 64] = msg_data;
      q_wr++;
    end
    if (!rst && mem_wr_en) begin
      mw_cnt++;
      mw_addr = mem_wr_addr;
      mw_data = mem_wr_data;
    end
  end

  // reference model
  int            m_st  [B];
  logic [N-1:0]  m_vec [B];
  logic [DW-1:0] m_mem [B];
  int fresh = 0;

  task automatic expect_msg(input int ty, input int de, input int ad, input logic [DW-1:0] da, input string tag);
    int t = 0;
    while (q_rd >= q_wr && t < 60) begin
      @(negedge clk); #1; t++;
    end
    if (q_rd >= q_wr) begin
      chk(1'b0, tag, 32'hFFFF_FFFF, {ty[3:0], de[3:0], ad[7:0], da});
    end else begin
      chk({q_ty[q_rd % 64], q_de[q_rd % 64], q_ad[q_rd % 64], q_da[q_rd % 64]} ==
          {ty[1:0], de[NWD-1:0], ad[AWD-1:0], da}, tag,
          {q_ty[q_rd % 64], q_de[q_rd % 64], q_ad[q_rd % 64], q_da[q_rd % 64]},
          {ty[1:0], de[NWD-1:0], ad[AWD-1:0], da});
      q_rd++;
    end
  endtask

  task automatic own_send(input logic [DW-1:0] d);
    @(negedge clk);
    own_valid = 1'b1;
    own_data  = d;
    @(negedge clk);
    own_valid = 1'b0;
  endtask

  task automatic wait_grant(input int n);
    int t = 0;
    forever begin
      #2;
      if (req_grant[n]) break;
      @(negedge clk);
      t++;
      if (t > 80) begin
        chk(1'b0, "R10 grant timeout", 0, 1);
        break;
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[n] = 1'b0;
  endtask

  task automatic issue(input int n, input int k, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid[n]         = 1'b1;
    req_kind[2*n +: 2]   = k[1:0];
    req_addr[AWD*n +: AWD] = a[AWD-1:0];
    req_wdata[DW*n +: DW] = d;
    wait_grant(n);
  endtask

  task automatic resolve(input int n, input int k, input int a, input logic [DW-1:0] d);
    logic [N-1:0] b;
    int own;
    int mw0;
    logic [DW-1:0] fd;
    b = N'(1) << n;
    mw0 = mw_cnt;
    if (k == K_RD || k == K_WR) begin
      if (m_st[a] == S_EXC && m_vec[a] != b) begin
        own = 0;
        for (int i = N - 1; i >= 0; i--) if (m_vec[a][i]) own = i;
        fresh++;
        fd = DW'(16'hA000 + fresh);
        expect_msg(M_FETCH, own, a, '0, (k == K_RD) ? "R5 fetch" : "R6 fetch");
        own_send(fd);
        expect_msg(M_DATA, n, a, fd, (k == K_RD) ? "R5 reply" : "R6 reply");
        chk(mw_cnt == mw0 + 1 && mw_addr == a[AWD-1:0] && mw_data == fd,
            (k == K_RD) ? "R5 memwrite" : "R6 memwrite", {mw_addr, mw_data}, {a[AWD-1:0], fd});
        m_mem[a] = fd;
        if (k == K_RD) begin m_st[a] = S_SHR; m_vec[a] = m_vec[a] | b; end
        else begin m_st[a] = S_EXC; m_vec[a] = b; end
      end else begin
        if (k == K_WR && m_st[a] == S_SHR)
          for (int i = 0; i < N; i++)
            if (m_vec[a][i] && i != n) expect_msg(M_INV, i, a, '0, "R4 invalidate");
        expect_msg(M_DATA, n, a, m_mem[a],
                   (m_st[a] == S_EXC) ? "R9 owner reply" :
                   (k == K_RD) ? "R2 reply" : (m_st[a] == S_SHR) ? "R4 reply" : "R3 reply");
        if (k == K_RD) begin
          if (m_st[a] == S_EXC) m_vec[a] = b; else m_vec[a] = m_vec[a] | b;
          m_st[a] = S_SHR;
        end else begin
          m_st[a] = S_EXC; m_vec[a] = b;
        end
      end
    end else if (k == K_WB && m_st[a] == S_EXC && m_vec[a] == b) begin
      for (int t = 0; t < 20 && mw_cnt == mw0; t++) begin @(negedge clk); #1; end
      chk(mw_cnt == mw0 + 1 && mw_addr == a[AWD-1:0] && mw_data == d, "R7 writeback",
          {mw_addr, mw_data}, {a[AWD-1:0], d});
      chk(q_wr == q_rd, "R7 no message", q_wr - q_rd, 0);
      m_mem[a] = d; m_st[a] = S_UNC; m_vec[a] = '0;
    end else begin
      repeat (8) @(negedge clk);
      #1;
      chk(mw_cnt == mw0, "R8 ignored no memwrite", mw_cnt, mw0);
      chk(q_wr == q_rd, "R8 ignored no message", q_wr - q_rd, 0);
    end
  endtask

  task automatic run_op(input int n, input int k, input int a, input logic [DW-1:0] d);
    issue(n, k, a, d);
    resolve(n, k, a, d);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int mw0;
    logic [DW-1:0] fd;
    for (int i = 0; i < B; i++) begin m_st[i] = S_UNC; m_vec[i] = '0; m_mem[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(msg_valid == 1'b0, "R1 no message after reset", msg_valid, 0);
    chk(mem_wr_en == 1'b0, "R1 no memwrite after reset", mem_wr_en, 0);
    chk(req_grant == '0, "R1 no grant after reset", req_grant, 0);

    // R1/R2/R3: first access to each block sees uncached state and zero data
    run_op(0, K_RD, 0, '0);
    run_op(2, K_RD, 1, '0);
    run_op(1, K_WR, 2, '0);
    run_op(3, K_RD, 3, '0);
    run_op(2, K_RD, 0, '0);

    // R10: same-cycle writes to block 0 from nodes 1 and 3
    @(negedge clk);
    req_valid[1] = 1'b1; req_kind[2 +: 2] = 2'(K_WR); req_addr[2 +: 2] = 2'd0;
    req_valid[3] = 1'b1; req_kind[6 +: 2] = 2'(K_WR); req_addr[6 +: 2] = 2'd0;
    #2;
    chk(req_grant == 4'b0010, "R10 lowest index wins", req_grant, 4'b0010);
    @(posedge clk); @(negedge clk);
    req_valid[1] = 1'b0;
    #1;
    chk(req_grant == '0, "R10 loser held while busy", req_grant, 0);
    resolve(1, K_WR, 0, '0);
    wait_grant(3);
    resolve(3, K_WR, 0, '0);

    // R11: stall during an owner fetch
    issue(2, K_RD, 0, '0);
    mw0 = mw_cnt;
    expect_msg(M_FETCH, 3, 0, '0, "R5 fetch busy case");
    req_valid[0] = 1'b1; req_kind[0 +: 2] = 2'(K_RD); req_addr[0 +: 2] = 2'd1;
    repeat (3) begin
      @(negedge clk); #2;
      chk(req_grant == '0, "R11 no grant while fetching", req_grant, 0);
    end
    req_valid[0] = 1'b0;
    fd = 16'h5A5A;
    own_send(fd);
    expect_msg(M_DATA, 2, 0, fd, "R5 reply busy case");
    chk(mw_cnt == mw0 + 1 && mw_data == fd, "R5 memwrite busy case", mw_data, fd);
    m_mem[0] = fd; m_st[0] = S_SHR; m_vec[0] = 4'b1100;

    // R11: stray owner response while idle
    mw0 = mw_cnt;
    own_send(16'hDEAD);
    repeat (3) @(negedge clk);
    #1;
    chk(mw_cnt == mw0, "R11 stray owner response ignored", mw_cnt, mw0);
    run_op(1, K_RD, 0, '0);

    // R8: reserved kind and foreign write-back
    run_op(0, K_BAD, 1, 16'h1111);
    run_op(0, K_WB, 0, 16'h2222);
    run_op(2, K_RD, 1, '0);

    // R9: owner misses
    run_op(0, K_WR, 3, '0);
    run_op(0, K_WR, 3, '0);
    run_op(0, K_RD, 3, '0);

    // R7: owner write-back, then a plain read sees the new data
    run_op(3, K_WR, 2, '0);
    run_op(3, K_WB, 2, 16'hBEEF);
    run_op(1, K_RD, 2, '0);

    // pseudo-random sweep over all nodes, blocks and kinds
    lfsr = 16'hACE1;
    for (int op = 0; op < 400; op++) begin
      int n, a, sel, k;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      n = int'(lfsr[1:0]);
      a = int'(lfsr[3:2]);
      sel = int'(lfsr[6:4]);
      if (sel < 3) k = K_RD;
      else if (sel < 6) k = K_WR;
      else if (sel == 6) begin
        k = K_WB;
        if (m_st[a] == S_EXC)
          for (int i = N - 1; i >= 0; i--) if (m_vec[a][i]) n = i;
      end else k = K_WB;
      run_op(n, k, a, lfsr ^ 16'(op));
    end

    repeat (10) @(negedge clk);
    #1;
    chk(q_wr == q_rd, "R8 no stray messages", q_wr - q_rd, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule